// File: doc/BRIEF.md
# External Bus Data Alignment Unit

This block sits between a 32-bit internal access port and an external memory data bus that is either 8 or 16 bits wide. It takes a byte, halfword or word read or write at a byte address, together with a region number. From the region it decides the external width. It then breaks the access into one, two or four external cycles. For each cycle it places the data on the proper byte lanes and raises a strobe for each lane in use. On reads it collects the returned lanes into a right-aligned 32-bit result.

Byte order is fixed while reset is applied, from a mode input. Each region's width comes from a configuration vector. Two regions override that vector and are always 16 bits wide: region 0 and the region given by the `SDRAM_REGION` parameter.

The internal side uses a valid/ready request handshake and returns a one-cycle response pulse. The external side presents one cycle at a time and holds it until the memory accepts it.

Top module: `bus_align_unit`

## Requirements
- R1: The byte order is sampled from `mode_le_pin` on every clock edge while `rst` is high. A 0 selects big endian and a 1 selects little endian. Changes on the pin after reset have no effect on any access.
- R2: In big endian mode the lowest byte address of an access holds the most significant data byte. In little endian mode it holds the least significant byte. This applies to both reads and writes.
- R3: A byte access to a 16-bit region is one cycle at the byte's own address. In big endian mode an even address uses the upper lane (data bits 15:8, `ext_strb` = 2'b10) and an odd address uses the lower lane (bits 7:0, `ext_strb` = 2'b01). Little endian mode swaps the lanes.
- R4: A halfword access to a 16-bit region is one cycle at the access address with `ext_strb` = 2'b11.
- R5: A word access to a 16-bit region is two cycles, at the address and then the address plus 2, each with `ext_strb` = 2'b11. In big endian mode data bits 31:16 go first. In little endian mode bits 15:0 go first.
- R6: An access to an 8-bit region takes one cycle per byte, at the address plus 0, 1, 2, 3 in turn. Every cycle uses only lane 7:0 with `ext_strb` = 2'b01.
- R7: Region 0 and region `SDRAM_REGION` are handled as 16 bits wide even when their `region_wide` bit is 0. Any other region is 16 bits wide when its `region_wide` bit is 1.
- R8: A misaligned request produces an error response (`rsp_valid` = 1 and `rsp_err` = 1) on the cycle after acceptance and no external cycle. A halfword at an odd address is misaligned, as is a word at an address not divisible by 4. `req_size` = 3 is also treated this way. Size encoding: 0 byte, 1 halfword, 2 word.
- R9: `req_ready` is 1 when the block is idle and 0 from acceptance until the access completes. While `ext_valid` is 1 and `ext_ready` is 0, the external address, data and strobes hold their values.
- R10: `rsp_valid` pulses on the cycle after the last external cycle is accepted. A read returns its data right-aligned with the unused upper bits zero. A write returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; byte order is sampled while it is high |
| mode_le_pin | input | 1 | Byte order strap: 0 big endian, 1 little endian |
| region_wide | input | NUM_REGIONS | Per-region width setting, 1 = 16-bit |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | ADDR_W | Byte address |
| req_region | input | REG_W | Region number of the access |
| req_wdata | input | 32 | Right-aligned write data |
| ext_valid | output | 1 | External cycle present |
| ext_ready | input | 1 | External cycle accepted |
| ext_write | output | 1 | External cycle direction |
| ext_addr | output | ADDR_W | External byte address of the cycle |
| ext_wdata | output | 16 | Lane-steered write data |
| ext_strb | output | 2 | Lane strobes, bit 1 upper lane, bit 0 lower lane |
| ext_rdata | input | 16 | Read lanes returned with ext_ready |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Misaligned or invalid request |
| rsp_rdata | output | 32 | Right-aligned read result |

## Verification
An accepted request shows its first external cycle one clock later, because every output comes from a register. An error response also arrives one clock after acceptance. Each later cycle appears one clock after the previous one is accepted, and the response comes one clock after the last acceptance. The bench drives requests and `ext_ready` on falling edges and samples at the following falling edge, so every check lands exactly where its result is due. Random stalls of zero to two cycles are inserted between cycles, so the hold rule and the busy state are checked at shifted times as well.

// File: rtl/bau_pkg.sv
`timescale 1ns/1ps
package bau_pkg;
  localparam int WORD_W = 32;
  localparam int LANE_W = 16;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_FULL = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;
endpackage

// File: rtl/bau_endian_latch.sv
`timescale 1ns/1ps
module bau_endian_latch (
  input  logic clk,
  input  logic rst,
  input  logic mode_pin,
  output logic is_le
);
  logic le_q;

  // sampled only while reset is held; frozen afterwards
  always_ff @(posedge clk) begin
    if (rst) le_q <= mode_pin;
  end

  assign is_le = le_q;
endmodule

// File: rtl/bau_planner.sv
`timescale 1ns/1ps
module bau_planner
  import bau_pkg::*;
#(
  parameter int NUM_REGIONS  = 8,
  parameter int SDRAM_REGION = 3,
  localparam int REG_W = $clog2(NUM_REGIONS)
) (
  input  acc_size_e              size,
  input  logic [1:0]             addr_lo,
  input  logic [REG_W-1:0]       region,
  input  logic [NUM_REGIONS-1:0] region_wide,
  output logic                   wide,
  output logic [1:0]             last_beat,
  output logic                   misaligned
);
  logic forced;

  assign forced = (region == REG_W'(0)) || (region == REG_W'(SDRAM_REGION));
  assign wide   = forced || region_wide[region];

  always_comb begin
    unique case (size)
      SZ_BYTE: last_beat = 2'd0;
      SZ_HALF: last_beat = wide ? 2'd0 : 2'd1;
      SZ_FULL: last_beat = wide ? 2'd1 : 2'd3;
      default: last_beat = 2'd0;
    endcase
  end

  assign misaligned = (size == SZ_BAD) ||
                      ((size == SZ_HALF) && addr_lo[0]) ||
                      ((size == SZ_FULL) && (addr_lo != 2'b00));
endmodule

// File: rtl/bau_lane_steer.sv
`timescale 1ns/1ps
module bau_lane_steer
  import bau_pkg::*;
(
  input  logic              is_le,
  input  acc_size_e         size,
  input  logic              wide,
  input  logic [1:0]        last_beat,
  input  logic [1:0]        beat,
  input  logic              addr_b0,
  input  logic [WORD_W-1:0] wdata,
  output logic [LANE_W-1:0] lane_data,
  output logic [1:0]        strb,
  output logic [1:0]        unit,
  output logic              hi_lane
);
  // unit = which slice of the right-aligned data this beat carries
  assign unit    = is_le ? beat : (last_beat - beat);
  assign hi_lane = is_le ? addr_b0 : ~addr_b0;

  always_comb begin
    if (wide && (size != SZ_BYTE)) begin
      lane_data = wdata[{unit[0], 4'b0000} +: LANE_W];
      strb      = 2'b11;
    end else if (wide) begin
      lane_data = hi_lane ? {wdata[7:0], 8'h00} : {8'h00, wdata[7:0]};
      strb      = hi_lane ? 2'b10 : 2'b01;
    end else begin
      lane_data = {8'h00, wdata[{unit, 3'b000} +: 8]};
      strb      = 2'b01;
    end
  end
endmodule

// File: rtl/bau_gather.sv
`timescale 1ns/1ps
module bau_gather
  import bau_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              capture,
  input  logic              wide,
  input  acc_size_e         size,
  input  logic [1:0]        unit,
  input  logic              hi_lane,
  input  logic [LANE_W-1:0] lane_in,
  output logic [WORD_W-1:0] acc_next
);
  logic [WORD_W-1:0] acc_q;
  logic [7:0]        byte_in;

  assign byte_in = (wide && hi_lane) ? lane_in[15:8] : lane_in[7:0];

  always_comb begin
    acc_next = acc_q;
    if (wide && (size != SZ_BYTE))
      acc_next[{unit[0], 4'b0000} +: LANE_W] = lane_in;
    else
      acc_next[{unit, 3'b000} +: 8] = byte_in;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) acc_q <= '0;
    else if (capture) acc_q <= acc_next;
  end
endmodule

// File: rtl/bus_align_unit.sv
`timescale 1ns/1ps
module bus_align_unit
  import bau_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int NUM_REGIONS  = 8,
  parameter int SDRAM_REGION = 3,
  localparam int REG_W = $clog2(NUM_REGIONS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   mode_le_pin,
  input  logic [NUM_REGIONS-1:0] region_wide,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [1:0]             req_size,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [REG_W-1:0]       req_region,
  input  logic [31:0]            req_wdata,
  output logic                   ext_valid,
  input  logic                   ext_ready,
  output logic                   ext_write,
  output logic [ADDR_W-1:0]      ext_addr,
  output logic [15:0]            ext_wdata,
  output logic [1:0]             ext_strb,
  input  logic [15:0]            ext_rdata,
  output logic                   rsp_valid,
  output logic                   rsp_err,
  output logic [31:0]            rsp_rdata
);
  logic endian_le;
  bau_endian_latch u_endian (
    .clk(clk), .rst(rst), .mode_pin(mode_le_pin), .is_le(endian_le)
  );

  acc_size_e  req_sz;
  logic       plan_wide, plan_bad;
  logic [1:0] plan_last;
  assign req_sz = acc_size_e'(req_size);

  bau_planner #(.NUM_REGIONS(NUM_REGIONS), .SDRAM_REGION(SDRAM_REGION)) u_plan (
    .size(req_sz), .addr_lo(req_addr[1:0]), .region(req_region),
    .region_wide(region_wide), .wide(plan_wide), .last_beat(plan_last),
    .misaligned(plan_bad)
  );

  // access context
  logic              busy_q, write_q, wide_q;
  acc_size_e         size_q;
  logic [1:0]        last_q, beat_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  // registered outputs
  logic              ext_valid_q;
  logic [ADDR_W-1:0] ext_addr_q;
  logic [LANE_W-1:0] ext_wdata_q;
  logic [1:0]        ext_strb_q, unit_q;
  logic              hilane_q;
  logic              rsp_valid_q, rsp_err_q;
  logic [WORD_W-1:0] rsp_rdata_q;

  logic accept, fire, last_fire;
  assign accept    = req_valid && !busy_q;
  assign fire      = ext_valid_q && ext_ready;
  assign last_fire = fire && (beat_q == last_q);

  // next-beat selection: new request or continuation
  acc_size_e         s_size;
  logic              s_wide, s_b0, s_big;
  logic [1:0]        s_last, s_beat;
  logic [ADDR_W-1:0] s_addr, nxt_addr;
  logic [WORD_W-1:0] s_wdata;

  assign s_size  = accept ? req_sz     : size_q;
  assign s_wide  = accept ? plan_wide  : wide_q;
  assign s_last  = accept ? plan_last  : last_q;
  assign s_beat  = accept ? 2'd0       : beat_q + 2'd1;
  assign s_addr  = accept ? req_addr   : addr_q;
  assign s_wdata = accept ? req_wdata  : wdata_q;
  assign s_b0    = s_addr[0];
  assign s_big   = s_wide && (s_size != SZ_BYTE);
  assign nxt_addr = s_addr + (s_big ? ADDR_W'({s_beat, 1'b0}) : ADDR_W'(s_beat));

  logic [LANE_W-1:0] st_data;
  logic [1:0]        st_strb, st_unit;
  logic              st_hi;

  bau_lane_steer u_steer (
    .is_le(endian_le), .size(s_size), .wide(s_wide), .last_beat(s_last),
    .beat(s_beat), .addr_b0(s_b0), .wdata(s_wdata),
    .lane_data(st_data), .strb(st_strb), .unit(st_unit), .hi_lane(st_hi)
  );

  logic [WORD_W-1:0] gather_next;
  bau_gather u_gather (
    .clk(clk), .rst(rst), .clear(accept), .capture(fire),
    .wide(wide_q), .size(size_q), .unit(unit_q), .hi_lane(hilane_q),
    .lane_in(ext_rdata), .acc_next(gather_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      write_q     <= 1'b0;
      wide_q      <= 1'b0;
      size_q      <= SZ_BYTE;
      last_q      <= 2'd0;
      beat_q      <= 2'd0;
      addr_q      <= '0;
      wdata_q     <= '0;
      ext_valid_q <= 1'b0;
      ext_addr_q  <= '0;
      ext_wdata_q <= '0;
      ext_strb_q  <= 2'b00;
      unit_q      <= 2'd0;
      hilane_q    <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (accept) begin
        if (plan_bad) begin
          rsp_valid_q <= 1'b1;
          rsp_err_q   <= 1'b1;
          rsp_rdata_q <= '0;
        end else begin
          busy_q      <= 1'b1;
          write_q     <= req_write;
          wide_q      <= plan_wide;
          size_q      <= req_sz;
          last_q      <= plan_last;
          beat_q      <= 2'd0;
          addr_q      <= req_addr;
          wdata_q     <= req_wdata;
          ext_valid_q <= 1'b1;
          ext_addr_q  <= nxt_addr;
          ext_wdata_q <= st_data;
          ext_strb_q  <= st_strb;
          unit_q      <= st_unit;
          hilane_q    <= st_hi;
        end
      end else if (last_fire) begin
        busy_q      <= 1'b0;
        ext_valid_q <= 1'b0;
        ext_strb_q  <= 2'b00;
        rsp_valid_q <= 1'b1;
        rsp_err_q   <= 1'b0;
        rsp_rdata_q <= write_q ? '0 : gather_next;
      end else if (fire) begin
        beat_q      <= s_beat;
        ext_addr_q  <= nxt_addr;
        ext_wdata_q <= st_data;
        ext_strb_q  <= st_strb;
        unit_q      <= st_unit;
        hilane_q    <= st_hi;
      end
    end
  end

  assign req_ready = !busy_q;
  assign ext_valid = ext_valid_q;
  assign ext_write = write_q;
  assign ext_addr  = ext_addr_q;
  assign ext_wdata = ext_wdata_q;
  assign ext_strb  = ext_strb_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rsp_rdata_q;
endmodule

// File: rtl/bau_checker.sv
`timescale 1ns/1ps
module bau_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              is_le,
  input logic              req_ready,
  input logic              ext_valid,
  input logic              ext_ready,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [15:0]       ext_wdata,
  input logic [1:0]        ext_strb,
  input logic              rsp_valid,
  input logic              rsp_err
);
  assert_endian_frozen_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(is_le));

  assert_lane_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    ext_valid |-> (ext_strb != 2'b00));

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> !ext_valid);

  assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
    ext_valid |-> !req_ready);

  assert_hold_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (ext_valid && !ext_ready) |=> (ext_valid && $stable(ext_addr) &&
                                   $stable(ext_wdata) && $stable(ext_strb)));

  assert_rsp_after_beat_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_err) |-> $past(ext_valid && ext_ready));
endmodule

bind bus_align_unit bau_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .is_le(endian_le), .req_ready(req_ready),
  .ext_valid(ext_valid), .ext_ready(ext_ready), .ext_addr(ext_addr),
  .ext_wdata(ext_wdata), .ext_strb(ext_strb), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err)
);

// File: tb/bus_align_unit_tb.sv
`timescale 1ns/1ps
module bus_align_unit_tb;
  localparam int ADDR_W = 32;
  localparam int NREG   = 8;

  logic        clk = 1'b0;
  logic        rst, mode_le_pin;
  logic [7:0]  region_wide;
  logic        req_valid, req_ready, req_write;
  logic [1:0]  req_size;
  logic [31:0] req_addr;
  logic [2:0]  req_region;
  logic [31:0] req_wdata;
  logic        ext_valid, ext_ready, ext_write;
  logic [31:0] ext_addr;
  logic [15:0] ext_wdata, ext_rdata;
  logic [1:0]  ext_strb;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;

  int  n_checks = 0;
  int  n_fail   = 0;
  int  stall_seed = 0;
  bit  cur_le;
  bit  done = 0;
  logic [7:0] mem [64];

  always #10 clk = ~clk;

  bus_align_unit #(.ADDR_W(ADDR_W), .NUM_REGIONS(NREG), .SDRAM_REGION(3)) u_dut (
    .clk(clk), .rst(rst), .mode_le_pin(mode_le_pin), .region_wide(region_wide),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_region(req_region),
    .req_wdata(req_wdata), .ext_valid(ext_valid), .ext_ready(ext_ready),
    .ext_write(ext_write), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_strb(ext_strb), .ext_rdata(ext_rdata), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit model_wide(input int rg);
    return region_wide[rg] || rg == 0 || rg == 3;
  endfunction

  function automatic logic [31:0] model_read(input int a, input int n, input bit le);
    logic [31:0] v = 0;
    for (int i = 0; i < n; i++) begin
      if (le) v = v | (32'(mem[a+i]) << (8*i));
      else    v = (v << 8) | 32'(mem[a+i]);
    end
    return v;
  endfunction

  task automatic fill_mem();
    for (int i = 0; i < 64; i++) mem[i] = 8'(i*7 + 3);
  endtask

  task automatic do_reset(input bit pin);
    rst = 1'b1; mode_le_pin = pin; req_valid = 1'b0; ext_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mode_le_pin = ~pin;   // R1: later pin changes must not matter
    cur_le = pin;
    fill_mem();
    @(negedge clk);
    chk(req_ready && !ext_valid && !rsp_valid, "R9 reset state",
        {29'b0, req_ready, ext_valid, rsp_valid}, 32'h4);
  endtask

  task automatic access(input bit wr, input int sz, input int a, input int rg,
                        input logic [31:0] wd, input string tag);
    int n, beats, step, ea, ev, hi_a, lo_a, st;
    bit bad, wide;
    logic [1:0]  exp_strb;
    logic [31:0] exp_rd, held_a;
    logic [15:0] held_d;
    logic [7:0]  want [4];
    n    = (sz == 3) ? 0 : (1 << sz);
    bad  = (sz == 3) || (sz == 1 && a % 2 != 0) || (sz == 2 && a % 4 != 0);
    wide = model_wide(rg);
    exp_rd = model_read(a, n, cur_le);
    for (int i = 0; i < n; i++)
      want[i] = cur_le ? wd[8*i +: 8] : wd[8*(n-1-i) +: 8];
    beats = (wide && n > 1) ? n/2 : (wide ? 1 : n);
    step  = (wide && n > 1) ? 2 : 1;

    @(negedge clk);
    chk(req_ready == 1'b1, {tag, " R9 ready when idle"}, 32'(req_ready), 1);
    req_write = wr; req_size = sz[1:0]; req_addr = a; req_region = rg[2:0];
    req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (bad) begin
      chk(rsp_valid && rsp_err, {tag, " R8 error response"}, {30'b0, rsp_valid, rsp_err}, 3);
      chk(!ext_valid, {tag, " R8 no external cycle"}, 32'(ext_valid), 0);
      @(negedge clk);
      chk(!ext_valid && !rsp_valid, {tag, " R8 still quiet"}, {30'b0, ext_valid, rsp_valid}, 0);
      return;
    end
    for (int k = 0; k < beats; k++) begin
      ea = a + k*step;
      if (!wide) exp_strb = 2'b01;
      else if (n > 1) exp_strb = 2'b11;
      else exp_strb = ((cur_le ? (a % 2 == 1) : (a % 2 == 0))) ? 2'b10 : 2'b01;
      st = stall_seed % 3; stall_seed++;
      for (int s = 0; s < st; s++) begin
        chk(ext_valid && !req_ready, {tag, " R9 busy during cycle"}, {30'b0, ext_valid, req_ready}, 2);
        held_a = ext_addr; held_d = ext_wdata;
        ext_ready = 1'b0;
        @(negedge clk);
        chk(ext_addr == held_a && ext_wdata == held_d, {tag, " R9 hold under stall"}, ext_addr, held_a);
      end
      chk(ext_valid == 1'b1, {tag, " cycle present"}, 32'(ext_valid), 1);
      chk(ext_addr == 32'(ea), {tag, " address"}, ext_addr, 32'(ea));
      chk(ext_strb == exp_strb, {tag, " strobes"}, 32'(ext_strb), 32'(exp_strb));
      chk(ext_write == wr, {tag, " direction"}, 32'(ext_write), 32'(wr));
      if (!wide) begin
        ext_rdata = {8'hA5, mem[ea]};
        if (wr && ext_strb[0]) mem[ea] = ext_wdata[7:0];
      end else begin
        ev   = ea & ~1;
        hi_a = cur_le ? ev + 1 : ev;
        lo_a = cur_le ? ev : ev + 1;
        ext_rdata = {mem[hi_a], mem[lo_a]};
        if (wr && ext_strb[1]) mem[hi_a] = ext_wdata[15:8];
        if (wr && ext_strb[0]) mem[lo_a] = ext_wdata[7:0];
      end
      ext_ready = 1'b1;
      @(negedge clk);
      ext_ready = 1'b0;
    end
    chk(rsp_valid && !rsp_err, {tag, " R10 response one cycle after last"},
        {30'b0, rsp_valid, rsp_err}, 2);
    chk(rsp_rdata == (wr ? 32'h0 : exp_rd), {tag, " R2 R10 read data"}, rsp_rdata,
        wr ? 32'h0 : exp_rd);
    if (wr)
      for (int i = 0; i < n; i++)
        chk(mem[a+i] == want[i], {tag, " R2 byte placed in memory"}, 32'(mem[a+i]), 32'(want[i]));
    @(negedge clk);
    chk(!rsp_valid && !ext_valid, {tag, " R10 single pulse"}, {30'b0, rsp_valid, ext_valid}, 0);
  endtask

  task automatic run_suite();
    access(0, 0, 4,  2, 0, "R3 byte even 16-bit");
    access(0, 0, 5,  2, 0, "R3 byte odd 16-bit");
    access(0, 1, 6,  2, 0, "R4 half 16-bit");
    access(0, 2, 8,  2, 0, "R5 word 16-bit");
    access(0, 0, 9,  1, 0, "R6 byte 8-bit");
    access(0, 1, 10, 1, 0, "R6 half 8-bit");
    access(0, 2, 12, 1, 0, "R6 word 8-bit");
    access(0, 2, 16, 0, 0, "R7 region0 forced");
    access(0, 1, 20, 3, 0, "R7 sdram forced");
    access(1, 2, 24, 2, 32'h11223344, "R5 word write 16-bit");
    access(1, 0, 29, 2, 32'h000000AB, "R3 byte write 16-bit");
    access(1, 2, 32, 1, 32'hCAFEBABE, "R6 word write 8-bit");
    access(1, 1, 38, 1, 32'h00005A6B, "R6 half write 8-bit");
    access(0, 2, 24, 2, 0, "R1 R2 readback");
    access(0, 1, 3,  2, 0, "R8 odd half");
    access(0, 2, 6,  1, 0, "R8 unaligned word");
    access(1, 3, 0,  2, 0, "R8 size 3");
  endtask

  initial begin
    region_wide = 8'b0000_0100;
    req_write = 0; req_size = 0; req_addr = 0; req_region = 0; req_wdata = 0;
    ext_rdata = 16'h0;
    do_reset(1'b0);
    run_suite();
    do_reset(1'b1);
    run_suite();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule